// File: doc/BRIEF.md
# RAM-Based Fixed Delay Line

This block delays a data word by a fixed number of clock cycles set by the parameter `DELAY`. Each enabled cycle it writes the incoming word into a small synchronous RAM and reads back, at the same address, the word stored one address period earlier. A register on the RAM read adds one cycle and an output register adds one more. The RAM address comes from a short sequence generator whose period is `DELAY-1`. The total latency is therefore exactly `DELAY` enabled cycles.

The generator has no lockup state. For `DELAY = 4` it is a 2-bit shift register with NOR feedback. For every other `DELAY` it is a down counter that wraps at zero. In both forms, any encoding outside the main cycle is steered back into it on the next enabled step. This matters when a reset is released unevenly across flip-flops and leaves the generator in an arbitrary state. If the address ever stopped advancing, the latency would fall to two cycles. The `SEED` parameter sets the state that reset loads into the generator. It lets such a partial-reset state be reproduced on purpose, for example an illegal encoding.

Top module: `ram_delay_line`

## Requirements
- R1: In steady state, `dout` after enabled clock edge k equals the `din` sampled at enabled clock edge k-DELAY, for any DELAY of 3 or more.
- R2: On every enabled cycle in which the generator is in its main cycle, the RAM address changes. The address repeats with period DELAY-1.
- R3: For DELAY = 4 the address generator is a 2-bit shift register with NOR feedback. It steps 00 to 01 to 10 and back to 00, and the unused state 11 steps to 10.
- R4: While `ce` is low, `dout`, the address and the stored words all hold their values. The delay is counted in enabled cycles only.
- R5: From any generator state loaded at reset (the `SEED` parameter, legal or not), the address is legal after one enabled step. R1 holds from the 2*DELAY-th enabled edge after reset onward.
- R6: While `rst` is high at a clock edge, `dout` is cleared to 0 and the generator is loaded with `SEED` (default 0).
- R7: For DELAY other than 4, the generator counts down from DELAY-2 to 0 and then reloads DELAY-2. Any state above DELAY-2 steps to DELAY-2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ce | input | 1 | Clock enable; low holds all state |
| din | input | WIDTH | Data word to delay |
| dout | output | WIDTH | `din` delayed by DELAY enabled cycles |

## Verification
The delay is checked with three input patterns. A counting ramp makes any wrong latency show up as an off-by-N value. An alternating 0x55/0xAA pattern with periodic enable gaps separates a correct hold from a design that counts disabled cycles. A pseudo-random stream with random enable gaps, applied after a mid-run reset, shows that recovery repeats cleanly. Four instances run side by side: the NOR and down-counter generators, each from a legal reset state and from an illegal or unused one. A generator that locks up therefore shows a two-cycle latency where the correct design shows `DELAY`.

// File: rtl/dl_pkg.sv
package dl_pkg;

    // Which address generator a given period selects.
    typedef enum logic {
        GEN_NOR2 = 1'b0,
        GEN_DOWN = 1'b1
    } gen_kind_e;

    function automatic gen_kind_e pick_gen(int unsigned period);
        return (period == 3) ? GEN_NOR2 : GEN_DOWN;
    endfunction

    function automatic int unsigned addr_bits(int unsigned period);
        return (period > 1) ? $clog2(period) : 1;
    endfunction

endpackage

// File: rtl/dl_addr_gen.sv
module dl_addr_gen
    import dl_pkg::*;
#(
    parameter int unsigned PERIOD = 6,
    parameter int unsigned AW     = 3,
    parameter int unsigned SEED   = 0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ce,
    output logic [AW-1:0] addr
);

    localparam gen_kind_e     KIND      = pick_gen(PERIOD);
    localparam logic [AW-1:0] LAST      = AW'(PERIOD - 1);
    localparam logic [AW-1:0] SEED_BITS = AW'(SEED);

    typedef struct packed {
        logic [AW-1:0] addr;
    } gen_st_t;

    gen_st_t       st_d, st_q;
    logic [AW-1:0] step;

    generate
        if (KIND == GEN_NOR2) begin : g_nor
            // 2-bit shift register with NOR feedback; 11 falls to 10
            always_comb begin
                step = {st_q.addr[0], ~(st_q.addr[0] | st_q.addr[1])};
            end

            AST_NOR_ESCAPE: assert property (@(posedge clk) disable iff (rst)
                (ce && st_q.addr == 2'b11) |=> (st_q.addr == 2'b10)); // R3
        end else begin : g_down
            // down counter; zero and any unused state reload LAST
            always_comb begin
                if (st_q.addr == '0 || st_q.addr > LAST) begin
                    step = LAST;
                end else begin
                    step = st_q.addr - 1'b1;
                end
            end
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.addr = SEED_BITS;
        end else if (ce) begin
            st_d.addr = step;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign addr = st_q.addr;

    AST_ADDR_ADVANCES: assert property (@(posedge clk) disable iff (rst)
        (ce && st_q.addr <= LAST) |=> (st_q.addr != $past(st_q.addr))); // R2

    AST_ADDR_RECOVERS: assert property (@(posedge clk) disable iff (rst)
        ce |=> (st_q.addr <= LAST)); // R5

    AST_ADDR_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !ce |=> $stable(st_q.addr)); // R4

endmodule

// File: rtl/dl_ram.sv
module dl_ram #(
    parameter int unsigned WIDTH = 8,
    parameter int unsigned AW    = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ce,
    input  logic [AW-1:0]    addr,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] rdata
);

    localparam int unsigned DEPTH = 1 << AW;

    typedef struct packed {
        logic [WIDTH-1:0] rdata;
    } ram_st_t;

    logic [WIDTH-1:0] mem [DEPTH];
    ram_st_t          st_d, st_q;

    // storage: read-before-write at one shared address
    always_ff @(posedge clk) begin
        if (ce) begin
            mem[addr] <= wdata;
        end
    end

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.rdata = '0;
        end else if (ce) begin
            st_d.rdata = mem[addr];
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign rdata = st_q.rdata;

    AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !ce |=> $stable(st_q.rdata)); // R4

endmodule

// File: rtl/ram_delay_line.sv
module ram_delay_line
    import dl_pkg::*;
#(
    parameter int unsigned WIDTH = 8,
    parameter int unsigned DELAY = 7,
    parameter int unsigned SEED  = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ce,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    localparam int unsigned PERIOD = DELAY - 1;
    localparam int unsigned AW     = addr_bits(PERIOD);

    typedef struct packed {
        logic [WIDTH-1:0] dout;
    } top_st_t;

    top_st_t          st_d, st_q;
    logic [AW-1:0]    addr;
    logic [WIDTH-1:0] rdata;

    dl_addr_gen #(
        .PERIOD (PERIOD),
        .AW     (AW),
        .SEED   (SEED)
    ) u_gen (
        .clk  (clk),
        .rst  (rst),
        .ce   (ce),
        .addr (addr)
    );

    dl_ram #(
        .WIDTH (WIDTH),
        .AW    (AW)
    ) u_ram (
        .clk   (clk),
        .rst   (rst),
        .ce    (ce),
        .addr  (addr),
        .wdata (din),
        .rdata (rdata)
    );

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.dout = '0;
        end else if (ce) begin
            st_d.dout = rdata;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign dout = st_q.dout;

    AST_OUT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !ce |=> $stable(dout)); // R4

endmodule

// File: tb/ram_delay_line_bench.sv
module ram_delay_line_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ce  = 1'b0;
    logic [7:0] din = 8'h00;
    logic [7:0] dout_a, dout_b, dout_c, dout_d;

    // a: down counter, legal seed; b: NOR, legal; c: NOR from 11; d: down from unused 7
    ram_delay_line #(.WIDTH(8), .DELAY(7), .SEED(0)) u_ram_delay_line (
        .clk(clk), .rst(rst), .ce(ce), .din(din), .dout(dout_a));
    ram_delay_line #(.WIDTH(8), .DELAY(4), .SEED(0)) u_ram_delay_line_n4 (
        .clk(clk), .rst(rst), .ce(ce), .din(din), .dout(dout_b));
    ram_delay_line #(.WIDTH(8), .DELAY(4), .SEED(3)) u_ram_delay_line_n4_bad (
        .clk(clk), .rst(rst), .ce(ce), .din(din), .dout(dout_c));
    ram_delay_line #(.WIDTH(8), .DELAY(7), .SEED(7)) u_ram_delay_line_d7_bad (
        .clk(clk), .rst(rst), .ce(ce), .din(din), .dout(dout_d));

    always #2 clk = ~clk;

    int         total = 0;
    int         bad   = 0;
    int         since = 0;
    int         edges = 0;
    bit         en_last  = 1'b0;
    bit         rst_last = 1'b0;
    logic [7:0] sb [$];
    logic [7:0] prev_a, prev_b, prev_c, prev_d;

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic chk_delay(string req, logic [7:0] act, int d);
        if (since >= 2 * d) begin
            chk(req, act, sb[sb.size() - 1 - d]);
        end
    endtask

    // driver side of the scoreboard: record every enabled input word
    always @(posedge clk) begin
        edges++;
        en_last  = ce;
        rst_last = rst;
        if (rst) begin
            since = 0;
            sb.delete();
        end else if (ce) begin
            sb.push_back(din);
            since++;
        end
    end

    // monitor: compare away from the active edge
    always @(negedge clk) begin
        if (edges > 0) begin
            if (rst_last) begin
                chk("R6", dout_a, 8'h00);
                chk("R6", dout_b, 8'h00);
                chk("R6", dout_c, 8'h00);
                chk("R6", dout_d, 8'h00);
            end else if (en_last) begin
                chk_delay("R1/R7", dout_a, 7);
                chk_delay("R3", dout_b, 4);
                chk_delay("R5 nor", dout_c, 4);
                chk_delay("R5 down", dout_d, 7);
            end else begin
                chk("R4", dout_a, prev_a);
                chk("R4", dout_b, prev_b);
                chk("R4", dout_c, prev_c);
                chk("R4", dout_d, prev_d);
            end
        end
        prev_a = dout_a;
        prev_b = dout_b;
        prev_c = dout_c;
        prev_d = dout_d;
    end

    task automatic drive(bit r, bit e, logic [7:0] d);
        @(negedge clk);
        rst = r;
        ce  = e;
        din = d;
    endtask

    initial begin
        logic [7:0] lf;
        lf = 8'hA5;
        drive(1'b1, 1'b1, 8'h00);
        drive(1'b1, 1'b1, 8'h00);
        // ramp, enable always on (R1, R3, R5)
        for (int i = 0; i < 60; i++) drive(1'b0, 1'b1, 8'(i + 1));
        // alternating pattern with enable gaps (R4)
        for (int i = 0; i < 60; i++)
            drive(1'b0, (i % 3) != 1, (i % 2) ? 8'hAA : 8'h55);
        // mid-run reset: generators reload their seeds again (R6, R5)
        drive(1'b1, 1'b0, 8'h11);
        drive(1'b1, 1'b1, 8'h22);
        // pseudo-random data with random enable gaps
        for (int i = 0; i < 150; i++) begin
            lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
            drive(1'b0, (lf[2:0] != 3'b000), lf ^ 8'(i));
        end
        drive(1'b0, 1'b0, 8'h00);
        drive(1'b0, 1'b0, 8'h00);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(4 * 200000);
        bad++;
        total++;
        $display("FAIL watchdog act=running exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule